// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for every beat of a four-word burst on a synchronous burst memory. A burst begins when a start address is loaded. Either of two independent strobes can load it: one from the processor side and one from the cache-controller side. After the load, the block works out each later beat address itself. It moves to the next beat only in a cycle where the advance input is high.

Only the two low-order address bits change during a burst. They follow one of two orders, picked by an order-select input at the moment of the load. The linear order counts upward from the starting word and wraps within the group of four. The interleaved order XORs the starting low bits with the beat number. The full current address is registered and drives the memory array directly.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `addr_out` and `beat_idx` to zero in that cycle.
- R2: At a rising edge where `proc_strobe` or `ctrl_strobe` is high, the block loads `start_addr` into `addr_out` and sets `beat_idx` to 0. Both outputs show the new values right after that edge.
- R3: At a rising edge where no strobe is high and `advance` is high, `beat_idx` increases by one, modulo 4.
- R4: When the order captured at the last load was linear (`order_sel` = 0), the low two bits of `addr_out` equal (starting low bits + `beat_idx`) mod 4. For a start of 1 the order is 1,2,3,0.
- R5: When the order captured at the last load was interleaved (`order_sel` = 1), the low two bits of `addr_out` equal the starting low bits XOR `beat_idx`. For a start of 1 the order is 1,0,3,2.
- R6: The bits of `addr_out` above bit 1 do not change while the block advances through a burst.
- R7: At a rising edge with no strobe and no advance, `addr_out` and `beat_idx` keep their values.
- R8: A strobe during a burst reloads the address and restarts the beat count at 0. When a strobe and `advance` are high at the same edge, the strobe wins.
- R9: `order_sel` is sampled only at a load. A change of `order_sel` between loads has no effect on `addr_out`.
- R10: After four advances, a burst wraps back to its starting address, in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe | input | 1 | Processor-side address strobe; loads the start address |
| ctrl_strobe | input | 1 | Controller-side address strobe; loads the start address |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Beat order taken at a load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Starting word address of a burst |
| addr_out | output | ADDR_W | Registered current word address |
| beat_idx | output | BEAT_W | Registered beat number within the burst |

## Verification
Every result of this block is due one clock after the edge that captures its stimulus. A load, an advance, a hold or a reset each shows on `addr_out` and `beat_idx` right after that single edge, and nothing is delayed further.

The bench drives its inputs at the falling edge and lets the next rising edge capture them. At that edge it updates its behavioural model. At the following falling edge it compares both outputs with the model. No result is ever sampled at the edge that produces it.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bsg_beat_counter.sv
module bsg_beat_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next
);
  logic [W-1:0] cnt_q;

  always_comb begin
    if (load)      cnt_next = '0;
    else if (step) cnt_next = cnt_q + 1'b1;
    else           cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bsg_order_map.sv
module bsg_order_map
  import bsg_pkg::*;
#(
  parameter int W = 2
) (
  input  order_e       order,
  input  logic [W-1:0] base_low,
  input  logic [W-1:0] beat,
  output logic [W-1:0] low
);
  always_comb begin
    if (order == ORDER_XOR) low = base_low ^ beat;
    else                    low = base_low + beat;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_idx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  order_e            mode_q;
  logic [BEAT_W-1:0] cnt_next;
  logic [BEAT_W-1:0] low_next;
  logic [ADDR_W-1:0] step_addr;
  logic [ADDR_W-1:0] addr_q;

  assign load = proc_strobe | ctrl_strobe;

  // Start address and order are captured together at a load.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= ORDER_LINEAR;
    end else if (load) begin
      base_q <= start_addr;
      mode_q <= order_e'(order_sel);
    end
  end

  bsg_beat_counter #(.W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (advance),
    .cnt      (beat_idx),
    .cnt_next (cnt_next)
  );

  bsg_order_map #(.W(BEAT_W)) u_map (
    .order    (mode_q),
    .base_low (base_q[BEAT_W-1:0]),
    .beat     (cnt_next),
    .low      (low_next)
  );

  generate
    if (UPPER_W > 0) begin : g_upper
      assign step_addr = {base_q[ADDR_W-1:BEAT_W], low_next};
    end else begin : g_no_upper
      assign step_addr = low_next;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (load)    addr_q <= start_addr;
    else if (advance) addr_q <= step_addr;
  end

  assign addr_out = addr_q;
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_strobe,
  input logic              ctrl_strobe,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat_idx
);
  logic              strobe;
  logic              loaded;
  logic [BEAT_W-1:0] cap_low;
  logic              cap_mode;

  assign strobe = proc_strobe | ctrl_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded   <= 1'b0;
      cap_low  <= '0;
      cap_mode <= 1'b0;
    end else if (strobe) begin
      loaded   <= 1'b1;
      cap_low  <= start_addr[BEAT_W-1:0];
      cap_mode <= order_sel;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat_idx == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (addr_out == $past(start_addr) && beat_idx == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe && advance) |=> (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));

  p_linear_r4: assert property (@(posedge clk) disable iff (rst)
    (loaded && !cap_mode) |->
      (addr_out[BEAT_W-1:0] == BEAT_W'(cap_low + beat_idx)));

  p_xor_r5: assert property (@(posedge clk) disable iff (rst)
    (loaded && cap_mode) |-> (addr_out[BEAT_W-1:0] == (cap_low ^ beat_idx)));

  p_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobe && advance) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !advance) |=> ($stable(addr_out) && $stable(beat_idx)));
endmodule

bind burst_addr_seq bsg_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .proc_strobe (proc_strobe),
  .ctrl_strobe (ctrl_strobe),
  .advance     (advance),
  .order_sel   (order_sel),
  .start_addr  (start_addr),
  .addr_out    (addr_out),
  .beat_idx    (beat_idx)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int ADDR_W = 19;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              proc_strobe = 1'b0;
  logic              ctrl_strobe = 1'b0;
  logic              advance = 1'b0;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [BEAT_W-1:0] beat_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int m_base = 0;
  int m_beat = 0;
  int m_mode = 0;
  int m_addr = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst(rst), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .advance(advance), .order_sel(order_sel), .start_addr(start_addr),
    .addr_out(addr_out), .beat_idx(beat_idx)
  );

  function automatic int low_of(int base, int beat, int mode);
    if (mode == 1) return (base % 4) ^ beat;
    return ((base % 4) + beat) % 4;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (addr_out !== ADDR_W'(m_addr) || beat_idx !== BEAT_W'(m_beat)) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_idx, ADDR_W'(m_addr), m_beat);
    end
  endtask

  // Drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic cyc(bit ps, bit cs, bit adv, bit md, int a, string tag);
    proc_strobe = ps;
    ctrl_strobe = cs;
    advance     = adv;
    order_sel   = md;
    start_addr  = ADDR_W'(a);
    @(posedge clk);
    if (rst) begin
      m_base = 0; m_beat = 0; m_mode = 0; m_addr = 0;
    end else if (ps || cs) begin
      m_base = a; m_beat = 0; m_mode = md; m_addr = a;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
      m_addr = (m_base - (m_base % 4)) + low_of(m_base, m_beat, m_mode);
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 1, 'h1234, "R1 reset with inputs active");
    cyc(0, 0, 1, 0, 'h55,   "R1 reset held");
    rst = 1'b0;

    // R2/R4/R10: processor strobe, linear from 1 -> 1,2,3,0,1
    cyc(1, 0, 0, 0, 'h2a5, "R2 proc strobe load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, "R4 R6 linear advance");
    // that last one wrapped
    checks++;
    if (addr_out !== ADDR_W'('h2a5)) begin
      fails++;
      $display("FAIL R10 linear wrap: addr=%h expected addr=%h", addr_out, ADDR_W'('h2a5));
    end
    // R7 hold
    cyc(0, 0, 0, 0, 'h7777, "R7 hold");
    cyc(0, 0, 0, 1, 'h1111, "R7 hold with other inputs");

    // R2/R5/R10: controller strobe, interleaved from 1 -> 1,0,3,2,1
    cyc(0, 1, 0, 1, 'h4fd, "R2 ctrl strobe load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, "R5 R6 xor advance");
    checks++;
    if (addr_out !== ADDR_W'('h4fd)) begin
      fails++;
      $display("FAIL R10 xor wrap: addr=%h expected addr=%h", addr_out, ADDR_W'('h4fd));
    end

    // R9: order_sel flips during a burst
    cyc(1, 0, 0, 0, 'h3e6, "R2 load linear");
    cyc(0, 0, 1, 1, 0, "R9 order change ignored");
    cyc(0, 0, 1, 1, 0, "R9 order change ignored");
    cyc(0, 0, 1, 0, 0, "R3 advance");
    cyc(0, 1, 0, 1, 'h3e6, "R2 load xor");
    cyc(0, 0, 1, 0, 0, "R9 order change ignored");
    cyc(0, 0, 1, 0, 0, "R9 order change ignored");

    // R8: reload mid-burst, strobe beats advance
    cyc(1, 0, 1, 0, 'h10b, "R8 strobe with advance");
    cyc(0, 0, 1, 0, 0, "R3 advance");
    cyc(0, 1, 1, 1, 'h7ff02, "R8 reload mid-burst");
    cyc(0, 0, 1, 0, 0, "R5 advance after reload");
    cyc(1, 1, 0, 0, 'h00, "R8 both strobes");
    cyc(0, 0, 1, 0, 0, "R4 advance");

    // Sweep every start low value in both orders with varied upper bits.
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(s[0], !s[0], 0, md[0], (s * 'h1357 + md * 'h2468 + 'h40) * 4 + s, "R2 sweep load");
        for (int k = 0; k < 5; k++) begin
          cyc(0, 0, 1, !md[0], 0, md ? "R5 sweep" : "R4 sweep");
          cyc(0, 0, 0, md[0], 0, "R7 sweep hold");
        end
      end
    end

    // Reset in the middle of a burst.
    cyc(0, 0, 1, 0, 0, "R3 advance");
    rst = 1'b1;
    cyc(0, 0, 1, 0, 0, "R1 reset mid-burst");
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, "R7 hold after reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule